// File: doc/BRIEF.md
# Multi-Port GPIO Register Block with Bus Slave

This block sits on a simple peripheral bus (APB) as a slave. It holds the software-visible registers for a bank of general-purpose pins. There are one to four ports, and each port can be up to 32 pins wide. Each port has three registers:

- a drive-value register, which sets the value put on the output pins;
- a direction register, in which a 1 turns that pin into an output;
- a read-only input-value register, which shows the pins as seen after a two-stage synchroniser.

The first port also owns a set of interrupt-control registers. The block does not evaluate interrupts. It passes these registers to a separate interrupt unit and reads back that unit's pending status. A write to the acknowledge location is forwarded to the interrupt unit as a one-cycle pulse that carries the written bits.

The register map is fixed, and some offsets are behavioural:

- Drive and direction registers form pairs. Port p has its drive register at 0x0C·p and its direction register at 0x0C·p + 4.
- Input-value registers sit at 0x50 + 4·p.
- The interrupt registers of the first port are:
  - 0x30: enable
  - 0x34: mask
  - 0x38: trigger type
  - 0x3C: polarity
  - 0x40: pending status (read-only)
  - 0x4C: acknowledge (write-only)

The block has no data streams. The bus handshake never stalls: the ready pin is always high and the error pin always low. All other pins are plain control and status signals.

Top module: `gpio_apb_regs`

## Requirements
- R1: After reset, every readable/writable register reads zero, so `pin_oe`, `pin_out` and all four interrupt-configuration outputs are zero and every pin is an input.
- R2: For each configured port p, a write to offset 0x0C·p sets the drive register and a write to 0x0C·p+4 sets the direction register. Both read back at the same offsets. `pin_out[32p+31:32p]` equals the drive register, and `pin_oe[32p+31:32p]` equals the direction register, where a 1 makes that pin an output.
- R3: Offset 0x50+4·p returns port p's `pin_in` slice through two flops. A pin change made between clock edges k-1 and k is first visible on `prdata` after edge k+1.
- R4: Writes to the input-value offsets are ignored: the readback still shows the pins, and no other register changes.
- R5: Bits at or above a port's configured width read as zero, are never driven on `pin_out` or `pin_oe`, and ignore written ones.
- R6: Reads of unmapped offsets return zero, and writes to them change nothing. Unmapped offsets include 0x08, 0x44 and 0x60, and the register pair and input-value offset of any port index at or above `NUM_PORTS`.
- R7: Offsets 0x30, 0x34, 0x38 and 0x3C hold the enable, mask, trigger-type and polarity bits for the first port. Each is read back at its offset and presented on `irq_en`, `irq_mask`, `irq_type` and `irq_pol`.
- R8: Offset 0x40 reads `irq_status` masked to the first port's width, and writes to it are ignored.
- R9: A write to 0x4C raises `irq_eoi_vld` for exactly the one cycle after the write edge, with `irq_eoi_data` equal to the written bits masked to the first port's width. A read of 0x4C returns zero.
- R10: `pready` is always 1 and `pslverr` always 0.
- R11: A register changes only in the access phase (`psel`, `penable` and `pwrite` all high). A setup phase alone writes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, zero outside read transfers |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Always 0 |
| pin_in | input | 32·NUM_PORTS | Raw pin levels, 32 bits per port |
| pin_out | output | 32·NUM_PORTS | Pin drive values |
| pin_oe | output | 32·NUM_PORTS | Pin output enables |
| irq_en | output | 32 | First-port interrupt enable bits |
| irq_mask | output | 32 | First-port interrupt mask bits |
| irq_type | output | 32 | First-port trigger-type bits |
| irq_pol | output | 32 | First-port polarity bits |
| irq_status | input | 32 | Pending bits from the interrupt unit |
| irq_eoi_vld | output | 1 | One-cycle acknowledge pulse |
| irq_eoi_data | output | 32 | Bits acknowledged, valid with the pulse |

## Verification
The register paths are exercised with several data patterns: alternating bits, all ones, and per-port distinct words.

- All-ones writes expose any bit above a port's width that leaks into storage or onto the pins.
- Distinct words per port reveal stride or port-index decode errors, where one port's access reaches another's register.

The input path is tested with a pin change held under a continuous read. This separates a correct two-flop delay from one flop or from three. Writes to read-only, write-only, absent-port and unmapped offsets are followed by reads and pin observations, which show whether any stored state was disturbed.

// File: rtl/gpio_apb_pkg.sv
package gpio_apb_pkg;
  localparam int unsigned MAX_PORTS = 4;
  localparam int unsigned WORD_W    = 32;

  // register map (byte offsets); strides are behavioural
  localparam logic [7:0] OFS_DRV_BASE = 8'h00;
  localparam logic [7:0] OFS_DIR_BASE = 8'h04;
  localparam logic [7:0] PAIR_STRIDE  = 8'h0C;
  localparam logic [7:0] OFS_INP_BASE = 8'h50;
  localparam logic [7:0] INP_STRIDE   = 8'h04;
  localparam logic [7:0] OFS_IRQ_EN   = 8'h30;
  localparam logic [7:0] OFS_IRQ_MSK  = 8'h34;
  localparam logic [7:0] OFS_IRQ_TYP  = 8'h38;
  localparam logic [7:0] OFS_IRQ_POL  = 8'h3C;
  localparam logic [7:0] OFS_IRQ_STA  = 8'h40;
  localparam logic [7:0] OFS_IRQ_EOI  = 8'h4C;

  typedef struct packed {
    logic [WORD_W-1:0] en;
    logic [WORD_W-1:0] msk;
    logic [WORD_W-1:0] typ;
    logic [WORD_W-1:0] pol;
  } irq_cfg_t;

  function automatic logic [WORD_W-1:0] width_mask(int unsigned w);
    return (w >= WORD_W) ? '1 : ((WORD_W'(1) << w) - WORD_W'(1));
  endfunction
endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= d;
      stab_q <= meta_q;
    end
  end

  assign q = stab_q;
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_apb_pkg::*;
#(
  parameter int unsigned PINS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_drv,
  input  logic              wr_dir,
  input  logic [PINS-1:0]   wdata,
  input  logic [PINS-1:0]   pins,
  output logic [WORD_W-1:0] drv_word,
  output logic [WORD_W-1:0] dir_word,
  output logic [WORD_W-1:0] inp_word
);
  logic [PINS-1:0] drv_q;
  logic [PINS-1:0] dir_q;
  logic [PINS-1:0] inp_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drv_q <= '0;
      dir_q <= '0;
    end else begin
      if (wr_drv) drv_q <= wdata;
      if (wr_dir) dir_q <= wdata;
    end
  end

  gpio_sync2 #(.W(PINS)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (pins),
    .q    (inp_s)
  );

  assign drv_word = WORD_W'(drv_q);
  assign dir_word = WORD_W'(dir_q);
  assign inp_word = WORD_W'(inp_s);
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_apb_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [7:0]        ofs,
  input  logic [W-1:0]      wdata,
  output irq_cfg_t          cfg,
  output logic              eoi_vld,
  output logic [WORD_W-1:0] eoi_data
);
  logic [W-1:0] en_q, msk_q, typ_q, pol_q, eoi_q;
  logic         eoi_vld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= '0;
      msk_q     <= '0;
      typ_q     <= '0;
      pol_q     <= '0;
      eoi_q     <= '0;
      eoi_vld_q <= 1'b0;
    end else begin
      if (wr && ofs == OFS_IRQ_EN)  en_q  <= wdata;
      if (wr && ofs == OFS_IRQ_MSK) msk_q <= wdata;
      if (wr && ofs == OFS_IRQ_TYP) typ_q <= wdata;
      if (wr && ofs == OFS_IRQ_POL) pol_q <= wdata;
      eoi_vld_q <= wr && (ofs == OFS_IRQ_EOI);
      eoi_q     <= (wr && ofs == OFS_IRQ_EOI) ? wdata : '0;
    end
  end

  assign cfg.en   = WORD_W'(en_q);
  assign cfg.msk  = WORD_W'(msk_q);
  assign cfg.typ  = WORD_W'(typ_q);
  assign cfg.pol  = WORD_W'(pol_q);
  assign eoi_vld  = eoi_vld_q;
  assign eoi_data = WORD_W'(eoi_q);
endmodule

// File: rtl/gpio_apb_regs.sv
module gpio_apb_regs
  import gpio_apb_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned NUM_PORTS = 4,
  parameter int unsigned PINS_A    = 32,
  parameter int unsigned PINS_B    = 32,
  parameter int unsigned PINS_C    = 32,
  parameter int unsigned PINS_D    = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        psel,
  input  logic                        penable,
  input  logic                        pwrite,
  input  logic [ADDR_W-1:0]           paddr,
  input  logic [31:0]                 pwdata,
  output logic [31:0]                 prdata,
  output logic                        pready,
  output logic                        pslverr,
  input  logic [NUM_PORTS*32-1:0]     pin_in,
  output logic [NUM_PORTS*32-1:0]     pin_out,
  output logic [NUM_PORTS*32-1:0]     pin_oe,
  output logic [31:0]                 irq_en,
  output logic [31:0]                 irq_mask,
  output logic [31:0]                 irq_type,
  output logic [31:0]                 irq_pol,
  input  logic [31:0]                 irq_status,
  output logic                        irq_eoi_vld,
  output logic [31:0]                 irq_eoi_data
);
  localparam int unsigned BUS_W = NUM_PORTS * WORD_W;

  function automatic int unsigned port_pins(int unsigned p);
    case (p)
      0:       return PINS_A;
      1:       return PINS_B;
      2:       return PINS_C;
      default: return PINS_D;
    endcase
  endfunction

  logic [7:0] ofs;
  logic       hi_ok;
  logic       wr_acc;
  logic       rd_sel;

  assign ofs    = paddr[7:0];
  assign hi_ok  = ((paddr >> 8) == '0);
  assign wr_acc = psel && penable && pwrite && hi_ok;
  assign rd_sel = psel && !pwrite && hi_ok;

  logic [WORD_W-1:0] drv_v [MAX_PORTS];
  logic [WORD_W-1:0] dir_v [MAX_PORTS];
  logic [WORD_W-1:0] inp_v [MAX_PORTS];

  for (genvar p = 0; p < MAX_PORTS; p++) begin : g_port
    localparam logic [7:0] A_DRV = 8'(OFS_DRV_BASE + p * PAIR_STRIDE);
    localparam logic [7:0] A_DIR = 8'(OFS_DIR_BASE + p * PAIR_STRIDE);
    if (p < NUM_PORTS) begin : g_on
      localparam int unsigned PW = port_pins(p);
      gpio_port_regs #(.PINS(PW)) u_port (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_drv  (wr_acc && ofs == A_DRV),
        .wr_dir  (wr_acc && ofs == A_DIR),
        .wdata   (pwdata[PW-1:0]),
        .pins    (pin_in[p*WORD_W +: PW]),
        .drv_word(drv_v[p]),
        .dir_word(dir_v[p]),
        .inp_word(inp_v[p])
      );
      assign pin_out[p*WORD_W +: WORD_W] = drv_v[p];
      assign pin_oe[p*WORD_W +: WORD_W]  = dir_v[p];
    end else begin : g_off
      assign drv_v[p] = '0;
      assign dir_v[p] = '0;
      assign inp_v[p] = '0;
    end
  end

  irq_cfg_t irq_cfg;

  gpio_irq_regs #(.W(PINS_A)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (wr_acc),
    .ofs     (ofs),
    .wdata   (pwdata[PINS_A-1:0]),
    .cfg     (irq_cfg),
    .eoi_vld (irq_eoi_vld),
    .eoi_data(irq_eoi_data)
  );

  assign irq_en   = irq_cfg.en;
  assign irq_mask = irq_cfg.msk;
  assign irq_type = irq_cfg.typ;
  assign irq_pol  = irq_cfg.pol;

  logic [WORD_W-1:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    for (int unsigned p = 0; p < MAX_PORTS; p++) begin
      if (ofs == 8'(OFS_DRV_BASE + p * PAIR_STRIDE)) rd_mux = drv_v[p];
      if (ofs == 8'(OFS_DIR_BASE + p * PAIR_STRIDE)) rd_mux = dir_v[p];
      if (ofs == 8'(OFS_INP_BASE + p * INP_STRIDE))  rd_mux = inp_v[p];
    end
    case (ofs)
      OFS_IRQ_EN:  rd_mux = irq_cfg.en;
      OFS_IRQ_MSK: rd_mux = irq_cfg.msk;
      OFS_IRQ_TYP: rd_mux = irq_cfg.typ;
      OFS_IRQ_POL: rd_mux = irq_cfg.pol;
      OFS_IRQ_STA: rd_mux = irq_status & width_mask(PINS_A);
      default: ;
    endcase
  end

  assign prdata  = rd_sel ? rd_mux : '0;
  assign pready  = 1'b1;
  assign pslverr = 1'b0;

  logic unused_bits;
  assign unused_bits = ^{pin_in, pwdata, irq_status, BUS_W[0]};
endmodule

// File: rtl/gpio_apb_regs_chk.sv
module gpio_apb_regs_chk #(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned NUM_PORTS = 4,
  parameter int unsigned PINS_A    = 32
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    psel,
  input logic                    penable,
  input logic                    pwrite,
  input logic [ADDR_W-1:0]       paddr,
  input logic [31:0]             pwdata,
  input logic [31:0]             prdata,
  input logic                    pready,
  input logic                    pslverr,
  input logic [NUM_PORTS*32-1:0] pin_out,
  input logic [NUM_PORTS*32-1:0] pin_oe,
  input logic [31:0]             irq_en,
  input logic [31:0]             irq_status,
  input logic                    irq_eoi_vld,
  input logic [31:0]             irq_eoi_data
);
  localparam logic [31:0] MASK_A = (PINS_A >= 32) ? '1 : ((32'd1 << PINS_A) - 32'd1);

  logic wr_acc;
  assign wr_acc = psel && penable && pwrite;

  a_r10_resp: assert property (@(posedge clk) disable iff (!rst_n)
    pready && !pslverr);

  a_r2_dir_a: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && paddr == ADDR_W'('h04))
      |=> (pin_oe[PINS_A-1:0] == $past(pwdata[PINS_A-1:0])));

  a_r11_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_acc |=> ($stable(pin_oe) && $stable(pin_out) && $stable(irq_en)));

  a_r9_eoi_src: assert property (@(posedge clk) disable iff (!rst_n)
    irq_eoi_vld |-> $past(wr_acc && paddr == ADDR_W'('h4C)));

  a_r9_eoi_data: assert property (@(posedge clk) disable iff (!rst_n)
    irq_eoi_vld |-> (irq_eoi_data == ($past(pwdata) & MASK_A)));

  a_r8_status: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && !pwrite && paddr == ADDR_W'('h40))
      |-> (prdata == (irq_status & MASK_A)));
endmodule

bind gpio_apb_regs gpio_apb_regs_chk #(
  .ADDR_W(ADDR_W), .NUM_PORTS(NUM_PORTS), .PINS_A(PINS_A)
) u_chk (.*);

// File: tb/sim_gpio_apb_regs.sv
`timescale 1ns/1ps
module sim_gpio_apb_regs;
  localparam int unsigned AW = 8;
  localparam int unsigned NP = 3;
  localparam int unsigned WA = 8;
  localparam int unsigned WB = 16;
  localparam int unsigned WC = 32;
  localparam logic [31:0] MA = 32'h0000_00FF;
  localparam logic [31:0] MB = 32'h0000_FFFF;
  localparam logic [31:0] MC = 32'hFFFF_FFFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic psel = 0, penable = 0, pwrite = 0;
  logic [AW-1:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic pready, pslverr;
  logic [NP*32-1:0] pin_in = '0;
  logic [NP*32-1:0] pin_out, pin_oe;
  logic [31:0] irq_en, irq_mask, irq_type, irq_pol;
  logic [31:0] irq_status = '0;
  logic irq_eoi_vld;
  logic [31:0] irq_eoi_data;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  gpio_apb_regs #(.ADDR_W(AW), .NUM_PORTS(NP), .PINS_A(WA), .PINS_B(WB),
                  .PINS_C(WC), .PINS_D(32)) u0 (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pslverr(pslverr), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .irq_en(irq_en), .irq_mask(irq_mask), .irq_type(irq_type), .irq_pol(irq_pol),
    .irq_status(irq_status), .irq_eoi_vld(irq_eoi_vld), .irq_eoi_data(irq_eoi_data)
  );

  task automatic chk(string req, logic [127:0] got, logic [127:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] pmask(int p);
    return (p == 0) ? MA : (p == 1) ? MB : MC;
  endfunction

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(negedge clk); penable = 1; #1;
    d = prdata;
    chk("R10 ready/err", {pready, pslverr}, 2'b10);
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 pin_oe", pin_oe, '0);
    chk("R1 pin_out", pin_out, '0);
    chk("R1 irq cfg", {irq_en, irq_mask, irq_type, irq_pol}, '0);
    for (int p = 0; p < NP; p++) begin
      rd(8'(p*12), d); chk("R1 drv", d, 0);
      rd(8'(p*12+4), d); chk("R1 dir", d, 0);
    end
  endtask

  task automatic t_port_rw();
    logic [31:0] d;
    logic [31:0] v;
    for (int p = 0; p < NP; p++) begin
      v = 32'hA5C3_5A3C ^ (32'h0101_0101 * (p + 1));
      wr(8'(p*12), v);
      wr(8'(p*12+4), ~v);
    end
    for (int p = 0; p < NP; p++) begin
      v = 32'hA5C3_5A3C ^ (32'h0101_0101 * (p + 1));
      rd(8'(p*12), d);   chk("R2 drv readback", d, v & pmask(p));
      rd(8'(p*12+4), d); chk("R2 dir readback", d, ~v & pmask(p));
      chk("R2 pin_out", pin_out[p*32 +: 32], v & pmask(p));
      chk("R2 pin_oe", pin_oe[p*32 +: 32], ~v & pmask(p));
    end
  endtask

  task automatic t_width();
    logic [31:0] d;
    wr(8'h00, 32'hFFFF_FFFF);
    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h00, d); chk("R5 drv A upper bits", d, MA);
    rd(8'h10, d); chk("R5 dir B upper bits", d, MB);
    chk("R5 pin_out A", pin_out[31:0], MA);
    chk("R5 pin_oe B", pin_oe[63:32], MB);
  endtask

  task automatic t_sync();
    @(negedge clk); psel = 1; pwrite = 0; paddr = 8'h50; penable = 0;
    @(negedge clk); penable = 1;
    pin_in[31:0] = 32'hFFFF_FF3C; #1;
    chk("R3 before edge", prdata, 32'h0);
    @(negedge clk); #1;
    chk("R3 after one edge", prdata, 32'h0);
    @(negedge clk); #1;
    chk("R3 after two edges", prdata, 32'h3C);
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic t_inputs_ro();
    logic [31:0] d;
    pin_in[63:32] = 32'h1234_BEEF;
    pin_in[95:64] = 32'hCAFE_F00D;
    repeat (3) @(negedge clk);
    rd(8'h54, d); chk("R3 input B", d, 32'h0000_BEEF);
    rd(8'h58, d); chk("R3 input C", d, 32'hCAFE_F00D);
    wr(8'h54, 32'h0);
    wr(8'h50, 32'h0);
    rd(8'h54, d); chk("R4 input B after write", d, 32'h0000_BEEF);
    rd(8'h50, d); chk("R4 input A after write", d, 32'h3C);
    rd(8'h00, d); chk("R4 drv A untouched", d, MA);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    logic [NP*32-1:0] so, se;
    so = pin_out; se = pin_oe;
    wr(8'h24, 32'hFFFF_FFFF);
    wr(8'h28, 32'hFFFF_FFFF);
    wr(8'h08, 32'hFFFF_FFFF);
    wr(8'h44, 32'hFFFF_FFFF);
    wr(8'h60, 32'hFFFF_FFFF);
    chk("R6 pin_out unchanged", pin_out, so);
    chk("R6 pin_oe unchanged", pin_oe, se);
    chk("R6 irq cfg unchanged", {irq_en, irq_mask, irq_type, irq_pol}, '0);
    rd(8'h24, d); chk("R6 absent port drv", d, 0);
    rd(8'h5C, d); chk("R6 absent port input", d, 0);
    rd(8'h08, d); chk("R6 hole 0x08", d, 0);
    rd(8'h44, d); chk("R6 hole 0x44", d, 0);
    rd(8'h60, d); chk("R6 beyond map", d, 0);
  endtask

  task automatic t_irq_cfg();
    logic [31:0] d;
    wr(8'h30, 32'h0000_0F81);
    wr(8'h34, 32'h0000_0042);
    wr(8'h38, 32'h0000_00C3);
    wr(8'h3C, 32'hFFFF_FF18);
    rd(8'h30, d); chk("R7 enable", d, 32'h81);
    rd(8'h34, d); chk("R7 mask", d, 32'h42);
    rd(8'h38, d); chk("R7 type", d, 32'hC3);
    rd(8'h3C, d); chk("R7 polarity", d, 32'h18);
    chk("R7 outputs", {irq_en, irq_mask, irq_type, irq_pol},
        {32'h81, 32'h42, 32'hC3, 32'h18});
    irq_status = 32'hABCD_EF5A;
    rd(8'h40, d); chk("R8 status", d, 32'h5A);
    wr(8'h40, 32'h0);
    rd(8'h40, d); chk("R8 status after write", d, 32'h5A);
    chk("R8 cfg untouched", irq_en, 32'h81);
  endtask

  task automatic t_eoi();
    logic [31:0] d;
    @(negedge clk); psel = 1; pwrite = 1; paddr = 8'h4C; pwdata = 32'h0000_F0A5; penable = 0;
    #1 chk("R9 no pulse in setup", irq_eoi_vld, 0);
    @(negedge clk); penable = 1;
    #1 chk("R9 no pulse before edge", irq_eoi_vld, 0);
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
    #1 chk("R9 pulse", {irq_eoi_vld, irq_eoi_data}, {1'b1, 32'hA5});
    @(negedge clk); #1 chk("R9 pulse one cycle", irq_eoi_vld, 0);
    rd(8'h4C, d); chk("R9 read zero", d, 0);
  endtask

  task automatic t_setup_only();
    logic [31:0] d;
    @(negedge clk); psel = 1; pwrite = 1; paddr = 8'h04; pwdata = 32'h0; penable = 0;
    repeat (3) @(negedge clk);
    psel = 0; pwrite = 0;
    rd(8'h04, d); chk("R11 setup phase writes nothing", d, ~(32'hA5C3_5A3C ^ 32'h0101_0101) & MA);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_port_rw();
    t_setup_only();
    t_width();
    t_sync();
    t_inputs_ro();
    t_unmapped();
    t_irq_cfg();
    t_eoi();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule